// File: doc/BRIEF.md
# Bus Address Range Trap Unit

This block watches the host bus for transactions and flags the ones that land on addresses of interest. Each presented transaction carries an address and a flag that says whether it targets memory space or I/O space. The unit compares it against four programmable windows and two fixed I/O ports. A window is set by a base, a size mask and a space select. The fixed ports are the keyboard-controller data and command addresses. Any match sets a sticky bit in one shared status word. The transaction itself is only observed, never blocked or changed.

Two enable masks turn the status bits into interrupt requests. One mask feeds a power-management (ACPI-style) request line. The other feeds a system-management (SMI) request line. The same status bit can drive either line, both lines or neither. Firmware sets up the windows through a small register port. When it has handled an event, it clears status bits by writing ones to them.

Top module: `bus_trap_unit`

## Requirements
- R1: After synchronous reset every register reads zero and both request outputs are low.
- R2: When `txn_valid` is high and the programmable window i is enabled, the status bit i is set at the next clock edge if the space type agrees and `(txn_addr & ~mask_i) == base_i`. A base with bits inside the mask therefore never matches. Windows occupy status bits 0 to 3.
- R3: A transaction whose space type differs from the window's select bit never sets that window's status bit. The select bit is 1 for I/O and 0 for memory.
- R4: A window whose enable bit is 0 never sets its status bit, even when its base and mask would match.
- R5: An I/O transaction to address 0x60 sets status bit 4, and one to address 0x64 sets status bit 5. A memory transaction to either address sets neither bit.
- R6: With `txn_valid` low, no status bit changes, whatever the address and space inputs are.
- R7: Status bits stay set until software writes the status register with a 1 in that bit position. Bits written with 0 keep their value.
- R8: When a match and a clear of the same status bit fall in the same cycle, the bit stays set.
- R9: `acpi_irq` is high exactly when some status bit is set whose bit in the ACPI enable register is also 1. It follows status and enable changes in the cycle after the clock edge that makes them.
- R10: `smi_irq` is high exactly when some status bit is set whose bit in the SMI enable register is also 1. It is independent of the ACPI enable register.
- R11: Register map on `cfg_addr`. Addresses 0 to 3 hold the window bases and 4 to 7 hold the window masks. Address 8 is the window control register: bit i enables window i and bit 4+i selects I/O for window i. Address 9 is the status register (write one to clear). Address 10 is the ACPI enable register and 11 the SMI enable register. `cfg_rdata` returns the addressed register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_valid | input | 1 | A host transaction is presented this cycle |
| txn_addr | input | 32 | Transaction address |
| txn_is_io | input | 1 | 1 for an I/O transaction, 0 for a memory transaction |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| acpi_irq | output | 1 | Power-management interrupt request |
| smi_irq | output | 1 | System-management interrupt request |

## Verification
Every result of this block is due one clock edge after its cause, and is then read combinationally. A matching transaction sets its status bit at the edge that samples it. A write to the status, enable or configuration registers takes effect at that same edge. The request lines then follow the new status and enables without any further register. The bench drives inputs on the falling edge and steps its reference model on the rising edge. It compares both request lines and all readback values on the next falling edge, so each check samples in the cycle where the result first appears.

// File: rtl/trap_pkg.sv
package trap_pkg;

    parameter int TRAP_AW = 32;
    parameter int NUM_RNG = 4;
    parameter int NUM_FIX = 2;

    localparam int NUM_TRAP  = NUM_RNG + NUM_FIX;
    localparam int REG_AW    = 4;
    localparam int RIDX_W    = (NUM_RNG > 1) ? $clog2(NUM_RNG) : 1;
    localparam int REG_MASK0 = NUM_RNG;
    localparam int REG_CTRL  = 2 * NUM_RNG;
    localparam int REG_STS   = REG_CTRL + 1;
    localparam int REG_ACPI  = REG_CTRL + 2;
    localparam int REG_SMI   = REG_CTRL + 3;

    typedef logic [TRAP_AW-1:0]  taddr_t;
    typedef logic [NUM_TRAP-1:0] tvec_t;

    typedef struct packed {
        logic   valid;
        logic   is_io;
        taddr_t addr;
    } txn_t;

    typedef struct packed {
        taddr_t base;
        taddr_t mask;
        logic   en;
        logic   is_io;
    } rng_cfg_t;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_BASE,
        RK_MASK,
        RK_CTRL,
        RK_STS,
        RK_ACPI,
        RK_SMI
    } reg_kind_t;

    function automatic reg_kind_t decode_kind(input logic [REG_AW-1:0] a);
        int unsigned ai;
        ai = int'(a);
        if (ai < NUM_RNG)              return RK_BASE;
        else if (ai < 2 * NUM_RNG)     return RK_MASK;
        else if (ai == REG_CTRL)       return RK_CTRL;
        else if (ai == REG_STS)        return RK_STS;
        else if (ai == REG_ACPI)       return RK_ACPI;
        else if (ai == REG_SMI)        return RK_SMI;
        else                           return RK_NONE;
    endfunction

    function automatic logic window_hit(input txn_t t, input rng_cfg_t c);
        return t.valid && c.en && (t.is_io == c.is_io)
               && ((t.addr & ~c.mask) == c.base);
    endfunction

    function automatic logic port_hit(input txn_t t, input taddr_t port);
        return t.valid && t.is_io && (t.addr == port);
    endfunction

endpackage

// File: rtl/trap_match.sv
module trap_match
    import trap_pkg::*;
#(
    parameter logic [NUM_FIX-1:0][TRAP_AW-1:0] FIX_ADDRS = {32'h0000_0064, 32'h0000_0060}
) (
    input  logic                     clk,
    input  logic                     rst,
    input  txn_t                     txn,
    input  rng_cfg_t [NUM_RNG-1:0]   rng_cfg,
    output tvec_t                    hit
);

    for (genvar gi = 0; gi < NUM_RNG; gi++) begin : g_win
        assign hit[gi] = window_hit(txn, rng_cfg[gi]);

        AST_WIN_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
            !rng_cfg[gi].en |-> !hit[gi]); // R4
        AST_WIN_SPACE: assert property (@(posedge clk) disable iff (rst)
            hit[gi] |-> (txn.is_io == rng_cfg[gi].is_io)); // R3
    end

    for (genvar gf = 0; gf < NUM_FIX; gf++) begin : g_fix
        assign hit[NUM_RNG + gf] = port_hit(txn, FIX_ADDRS[gf]);
    end

    AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (rst)
        !txn.valid |-> (hit == '0)); // R6
    AST_FIX_IO_ONLY: assert property (@(posedge clk) disable iff (rst)
        (txn.valid && !txn.is_io) |-> (hit[NUM_TRAP-1:NUM_RNG] == '0)); // R5

endmodule

// File: rtl/trap_regs.sv
module trap_regs
    import trap_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_we,
    input  logic [REG_AW-1:0]       cfg_addr,
    input  taddr_t                  cfg_wdata,
    input  tvec_t                   sts,
    output taddr_t                  cfg_rdata,
    output rng_cfg_t [NUM_RNG-1:0]  rng_cfg,
    output tvec_t                   acpi_en,
    output tvec_t                   smi_en,
    output tvec_t                   sts_clr
);

    reg_kind_t            kind;
    logic [REG_AW-1:0]    off;
    logic [RIDX_W-1:0]    ridx;

    always_comb begin
        kind = decode_kind(cfg_addr);
        off  = (kind == RK_MASK) ? (cfg_addr - REG_AW'(REG_MASK0)) : cfg_addr;
        ridx = off[RIDX_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rng_cfg <= '0;
            acpi_en <= '0;
            smi_en  <= '0;
        end else if (cfg_we) begin
            for (int i = 0; i < NUM_RNG; i++) begin
                if (kind == RK_BASE && int'(ridx) == i) rng_cfg[i].base <= cfg_wdata;
                if (kind == RK_MASK && int'(ridx) == i) rng_cfg[i].mask <= cfg_wdata;
                if (kind == RK_CTRL) begin
                    rng_cfg[i].en    <= cfg_wdata[i];
                    rng_cfg[i].is_io <= cfg_wdata[NUM_RNG + i];
                end
            end
            if (kind == RK_ACPI) acpi_en <= cfg_wdata[NUM_TRAP-1:0];
            if (kind == RK_SMI)  smi_en  <= cfg_wdata[NUM_TRAP-1:0];
        end
    end

    assign sts_clr = (cfg_we && kind == RK_STS) ? cfg_wdata[NUM_TRAP-1:0] : '0;

    always_comb begin
        cfg_rdata = '0;
        unique case (kind)
            RK_BASE: cfg_rdata = rng_cfg[ridx].base;
            RK_MASK: cfg_rdata = rng_cfg[ridx].mask;
            RK_CTRL: begin
                for (int i = 0; i < NUM_RNG; i++) begin
                    cfg_rdata[i]           = rng_cfg[i].en;
                    cfg_rdata[NUM_RNG + i] = rng_cfg[i].is_io;
                end
            end
            RK_STS:  cfg_rdata[NUM_TRAP-1:0] = sts;
            RK_ACPI: cfg_rdata[NUM_TRAP-1:0] = acpi_en;
            RK_SMI:  cfg_rdata[NUM_TRAP-1:0] = smi_en;
            default: cfg_rdata = '0;
        endcase
    end

    AST_CLR_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |-> (sts_clr == '0)); // R7

endmodule

// File: rtl/trap_status.sv
module trap_status
    import trap_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  tvec_t hit,
    input  tvec_t clr,
    input  tvec_t acpi_en,
    input  tvec_t smi_en,
    output tvec_t sts,
    output logic  acpi_irq,
    output logic  smi_irq
);

    tvec_t sts_q;

    always_ff @(posedge clk) begin
        if (rst) sts_q <= '0;
        else     sts_q <= (sts_q & ~clr) | hit;
    end

    assign sts      = sts_q;
    assign acpi_irq = |(sts_q & acpi_en);
    assign smi_irq  = |(sts_q & smi_en);

    AST_HIT_SETS: assert property (@(posedge clk) disable iff (rst)
        (hit != '0) |=> ((sts_q & $past(hit)) == $past(hit))); // R8
    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        (clr == '0) |=> ((sts_q & $past(sts_q)) == $past(sts_q))); // R7
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
        ((clr & ~hit) != '0) |=> ((sts_q & $past(clr & ~hit)) == '0)); // R7

endmodule

// File: rtl/bus_trap_unit.sv
module bus_trap_unit
    import trap_pkg::*;
#(
    parameter logic [NUM_FIX-1:0][TRAP_AW-1:0] FIX_ADDRS = {32'h0000_0064, 32'h0000_0060}
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               txn_valid,
    input  logic [TRAP_AW-1:0] txn_addr,
    input  logic               txn_is_io,
    input  logic               cfg_we,
    input  logic [REG_AW-1:0]  cfg_addr,
    input  logic [TRAP_AW-1:0] cfg_wdata,
    output logic [TRAP_AW-1:0] cfg_rdata,
    output logic               acpi_irq,
    output logic               smi_irq
);

    txn_t                   txn;
    rng_cfg_t [NUM_RNG-1:0] rng_cfg;
    tvec_t                  hit;
    tvec_t                  sts;
    tvec_t                  sts_clr;
    tvec_t                  acpi_en;
    tvec_t                  smi_en;

    assign txn = '{valid: txn_valid, is_io: txn_is_io, addr: txn_addr};

    trap_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .sts       (sts),
        .cfg_rdata (cfg_rdata),
        .rng_cfg   (rng_cfg),
        .acpi_en   (acpi_en),
        .smi_en    (smi_en),
        .sts_clr   (sts_clr)
    );

    trap_match #(.FIX_ADDRS(FIX_ADDRS)) u_match (
        .clk     (clk),
        .rst     (rst),
        .txn     (txn),
        .rng_cfg (rng_cfg),
        .hit     (hit)
    );

    trap_status u_status (
        .clk      (clk),
        .rst      (rst),
        .hit      (hit),
        .clr      (sts_clr),
        .acpi_en  (acpi_en),
        .smi_en   (smi_en),
        .sts      (sts),
        .acpi_irq (acpi_irq),
        .smi_irq  (smi_irq)
    );

    AST_IRQ_NEEDS_STS: assert property (@(posedge clk) disable iff (rst)
        (acpi_irq || smi_irq) |-> (sts != '0)); // R9
    AST_IDLE_STS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!txn_valid && !cfg_we) |=> $stable(sts)); // R6

endmodule

// File: tb/bus_trap_unit_tb.sv
`timescale 1ns/1ps
module bus_trap_unit_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        txn_valid;
    logic [31:0] txn_addr;
    logic        txn_is_io;
    logic        cfg_we;
    logic [3:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        acpi_irq;
    logic        smi_irq;

    always #10 clk = ~clk;

    bus_trap_unit u_dut (
        .clk(clk), .rst(rst), .txn_valid(txn_valid), .txn_addr(txn_addr),
        .txn_is_io(txn_is_io), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .acpi_irq(acpi_irq), .smi_irq(smi_irq)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [31:0] m_base [4];
    logic [31:0] m_mask [4];
    logic [7:0]  m_ctrl;
    logic [5:0]  m_sts, m_acpi, m_smi;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [5:0] model_hit(input logic [31:0] a, input logic io);
        logic [5:0] h = '0;
        for (int i = 0; i < 4; i++)
            if (m_ctrl[i] && (m_ctrl[4+i] == io) && ((a & ~m_mask[i]) == m_base[i])) h[i] = 1'b1;
        if (io && a == 32'h60) h[4] = 1'b1;
        if (io && a == 32'h64) h[5] = 1'b1;
        return h;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin m_base[i] = '0; m_mask[i] = '0; end
        m_ctrl = '0; m_sts = '0; m_acpi = '0; m_smi = '0;
    endtask

    task automatic tick();
        logic [5:0] h, c;
        @(posedge clk);
        if (rst) model_reset();
        else begin
            h = txn_valid ? model_hit(txn_addr, txn_is_io) : 6'd0;
            c = (cfg_we && cfg_addr == 4'd9) ? cfg_wdata[5:0] : 6'd0;
            m_sts = (m_sts & ~c) | h;
            if (cfg_we) begin
                if (cfg_addr < 4)                       m_base[cfg_addr[1:0]] = cfg_wdata;
                else if (cfg_addr < 8)                  m_mask[cfg_addr[1:0]] = cfg_wdata;
                else if (cfg_addr == 8)                 m_ctrl = cfg_wdata[7:0];
                else if (cfg_addr == 10)                m_acpi = cfg_wdata[5:0];
                else if (cfg_addr == 11)                m_smi  = cfg_wdata[5:0];
            end
        end
        @(negedge clk);
        check(acpi_irq == |(m_sts & m_acpi), "R9 acpi_irq per cycle", {31'd0, acpi_irq}, {31'd0, |(m_sts & m_acpi)});
        check(smi_irq  == |(m_sts & m_smi),  "R10 smi_irq per cycle", {31'd0, smi_irq},  {31'd0, |(m_sts & m_smi)});
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        tick();
        cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    task automatic txn(input logic [31:0] a, input logic io);
        txn_valid = 1'b1; txn_addr = a; txn_is_io = io;
        tick();
        txn_valid = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        cfg_addr = a;
        #1;
        check(cfg_rdata == exp, tag, cfg_rdata, exp);
    endtask

    task automatic rd_sts(input logic [5:0] exp, input string tag);
        rd(4'd9, {26'd0, exp}, tag);
        check(exp == m_sts, {tag, " (model)"}, {26'd0, m_sts}, {26'd0, exp});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        rst = 1'b1; txn_valid = 1'b0; txn_addr = '0; txn_is_io = 1'b0;
        cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        @(negedge clk);
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1: all registers zero after reset
        for (int a = 0; a < 12; a++) rd(4'(a), 32'd0, "R1 reset register value");
        check(!acpi_irq && !smi_irq, "R1 requests low", {30'd0, acpi_irq, smi_irq}, 32'd0);

        // R11: configuration and readback
        wr(4'd0, 32'h1000_0000); wr(4'd4, 32'h0000_0FFF);
        wr(4'd1, 32'h0000_0300); wr(4'd5, 32'h0000_0007);
        wr(4'd2, 32'h0000_2000); wr(4'd6, 32'h0000_000F);
        wr(4'd3, 32'h0000_0400); wr(4'd7, 32'h0000_00FF);
        wr(4'd8, 32'h0000_0027);
        rd(4'd1, 32'h0000_0300, "R11 base1 readback");
        rd(4'd7, 32'h0000_00FF, "R11 mask3 readback");
        rd(4'd8, 32'h0000_0027, "R11 control readback");

        // R2: memory window 0
        txn(32'h1000_0ABC, 1'b0);
        rd_sts(6'h01, "R2 memory window hit");
        // R3: wrong space
        txn(32'h1000_0ABC, 1'b1);
        txn(32'h0000_2005, 1'b1);
        rd_sts(6'h01, "R3 space mismatch ignored");
        // R2: I/O window 1
        txn(32'h0000_0305, 1'b1);
        rd_sts(6'h03, "R2 I/O window hit");
        txn(32'h0000_0308, 1'b1);
        rd_sts(6'h03, "R2 outside window no hit");
        // R4: disabled window 3
        txn(32'h0000_0410, 1'b0);
        txn(32'h0000_0410, 1'b1);
        rd_sts(6'h03, "R4 disabled window ignored");

        // R7: clear all
        wr(4'd9, 32'h0000_003F);
        rd_sts(6'h00, "R7 write one clears");
        // R6: no valid
        txn_valid = 1'b0; txn_addr = 32'h0000_0305; txn_is_io = 1'b1;
        tick();
        txn_addr = 32'h0000_0060;
        tick();
        rd_sts(6'h00, "R6 invalid transaction ignored");

        // R5: fixed ports
        txn(32'h0000_0060, 1'b1);
        rd_sts(6'h10, "R5 port 0x60 hit");
        txn(32'h0000_0064, 1'b0);
        rd_sts(6'h10, "R5 memory at 0x64 ignored");
        txn(32'h0000_0064, 1'b1);
        rd_sts(6'h30, "R5 port 0x64 hit");

        // R7: partial clear
        wr(4'd9, 32'h0000_0010);
        rd_sts(6'h20, "R7 clear only written bits");

        // R8: set and clear in same cycle
        txn_valid = 1'b1; txn_addr = 32'h0000_0060; txn_is_io = 1'b1;
        cfg_we = 1'b1; cfg_addr = 4'd9; cfg_wdata = 32'h0000_0010;
        tick();
        txn_valid = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
        rd_sts(6'h30, "R8 set wins over clear");

        // R9 / R10: enables
        wr(4'd10, 32'h0000_0020);
        check(acpi_irq == 1'b1, "R9 acpi raised by enabled bit", {31'd0, acpi_irq}, 32'd1);
        check(smi_irq == 1'b0, "R10 smi independent of acpi enable", {31'd0, smi_irq}, 32'd0);
        wr(4'd11, 32'h0000_0001);
        check(smi_irq == 1'b0, "R10 smi low with bit0 clear", {31'd0, smi_irq}, 32'd0);
        txn(32'h1000_0000, 1'b0);
        check(smi_irq == 1'b1, "R10 smi raised after hit", {31'd0, smi_irq}, 32'd1);
        rd(4'd11, 32'h0000_0001, "R11 smi enable readback");
        wr(4'd9, 32'h0000_0020);
        check(acpi_irq == 1'b0, "R9 acpi dropped after clear", {31'd0, acpi_irq}, 32'd0);
        check(smi_irq == 1'b1, "R10 smi kept", {31'd0, smi_irq}, 32'd1);
        wr(4'd9, 32'h0000_003F);
        check(!acpi_irq && !smi_irq, "R9 both low after full clear", {30'd0, acpi_irq, smi_irq}, 32'd0);

        // R2: base with bits inside mask never matches
        wr(4'd2, 32'h0000_2003);
        txn(32'h0000_2003, 1'b0);
        rd_sts(6'h00, "R2 base bits inside mask no match");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule